// File: doc/BRIEF.md
# Receive FIFO Burst Admission Controller

This block sits beside a host-side receive engine. It decides when the engine may open an inbound transaction (a burst) and how many packets that burst may hold. It keeps a small configuration word with three fields: a thresholding enable, a packet-count threshold and a burst cap. It compares these against the receive FIFO's free space, counted in packets. The link context also shapes the decision: the operating mode, the speed class and the endpoint kind.

When the engine raises `req_i` while `start_ok_o` is high, a burst starts on that clock edge. The granted length is latched at that edge. The remaining-packet counter then counts down on each received packet. The burst closes when the counter empties, or at once on an end or abort indication. No new start is permitted while a burst is open.

Top module: `rx_burst_admit`

## Requirements
- R1: Outside the multi-packet rule (enable bit 0, `host_mode_i`=0, or `speed_i` other than 2'b11), `start_ok_o` is 1 exactly when no burst is active and `free_slots_i` >= 1; a request without permit starts nothing.
- R2: With enable 1, `host_mode_i`=1 and `speed_i`=2'b11, `start_ok_o` is 1 exactly when no burst is active and `free_slots_i` >= the programmed packet count.
- R3: After reset, the enable bit is 1, the packet count is 2 and the burst cap is 16; `burst_active_o`, `grant_len_o` and `pkts_left_o` are 0.
- R4: A written packet count of 0 acts as 1. A written burst cap of 0 acts as 1, and a cap above 16 acts as 16.
- R5: On a start, `grant_len_o` = min(cap, `free_slots_i`). The cap is the programmed burst size only under the multi-packet rule and for `ep_kind_i` of isochronous (1), bulk (2) or interrupt (3); otherwise, including control (0), the cap is 16.
- R6: `grant_len_o` is latched when a burst starts and holds for the whole burst, even if the configuration is written meanwhile.
- R7: While a burst is active, `start_ok_o` is 0. Each `pkt_rcvd_i` pulse decrements `pkts_left_o`, and the burst ends when it reaches 0.
- R8: `burst_end_i` during a burst closes it on the next edge and clears `pkts_left_o`, whatever the count.
- R9: A configuration written during a burst is applied at the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_wr_i | input | 1 | Write strobe for the configuration fields |
| cfg_thr_en_i | input | 1 | Multi-packet thresholding enable |
| cfg_pkt_cnt_i | input | 4 | Packet-count threshold |
| cfg_burst_i | input | 5 | Burst cap in packets |
| free_slots_i | input | 6 | FIFO free space in packets |
| host_mode_i | input | 1 | 1 = host mode |
| speed_i | input | 2 | Speed class, 2'b11 = highest |
| ep_kind_i | input | 2 | 0 control, 1 isochronous, 2 bulk, 3 interrupt |
| req_i | input | 1 | Engine requests a burst start |
| pkt_rcvd_i | input | 1 | One packet received in the burst |
| burst_end_i | input | 1 | End or abort of the current burst |
| start_ok_o | output | 1 | Start permit |
| burst_active_o | output | 1 | A burst is open |
| grant_len_o | output | 5 | Latched granted burst length |
| pkts_left_o | output | 5 | Packets remaining in the burst |

## Verification
The hardest case to reach from the ports is a configuration write that lands inside an open burst. The bench opens a three-packet burst and consumes one packet. It then writes a cap of 1 and checks that the grant still reads 3. After draining the burst, it starts again and expects a grant of 1. Clamping of illegal fields is observed through the grant length at the next start.

// File: rtl/rxadm_pkg.sv
package rxadm_pkg;
  localparam int CNT_W   = 4;
  localparam int BURST_W = 5;

  typedef enum logic [1:0] {
    EP_CTRL = 2'd0,
    EP_ISOC = 2'd1,
    EP_BULK = 2'd2,
    EP_INTR = 2'd3
  } ep_kind_e;

  localparam logic [1:0] SPEED_TOP = 2'b11;

  typedef struct packed {
    logic               thr_en;
    logic [CNT_W-1:0]   pkt_cnt;
    logic [BURST_W-1:0] burst;
  } rxadm_cfg_t;
endpackage

// File: rtl/rxadm_cfg.sv
module rxadm_cfg
  import rxadm_pkg::*;
#(
  parameter int MAX_BURST = 16,
  parameter int RST_CNT   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic               thr_en_i,
  input  logic [CNT_W-1:0]   pkt_cnt_i,
  input  logic [BURST_W-1:0] burst_i,
  output rxadm_cfg_t         cfg_o
);
  rxadm_cfg_t cfg_d;

  // clamp illegal fields on write
  always_comb begin
    cfg_d.thr_en  = thr_en_i;
    cfg_d.pkt_cnt = (pkt_cnt_i == '0) ? CNT_W'(1) : pkt_cnt_i;
    if (burst_i == '0)
      cfg_d.burst = BURST_W'(1);
    else if (burst_i > BURST_W'(MAX_BURST))
      cfg_d.burst = BURST_W'(MAX_BURST);
    else
      cfg_d.burst = burst_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o.thr_en  <= 1'b1;
      cfg_o.pkt_cnt <= CNT_W'(RST_CNT);
      cfg_o.burst   <= BURST_W'(MAX_BURST);
    end else if (wr_i) begin
      cfg_o <= cfg_d;
    end
  end

  AST_CFG_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_o.pkt_cnt != '0) && (cfg_o.burst != '0) && (cfg_o.burst <= BURST_W'(MAX_BURST))); // R4
endmodule

// File: rtl/rxadm_policy.sv
module rxadm_policy
  import rxadm_pkg::*;
#(
  parameter int FREE_W    = 6,
  parameter int MAX_BURST = 16
) (
  input  rxadm_cfg_t         cfg_i,
  input  logic [FREE_W-1:0]  free_slots_i,
  input  logic               host_mode_i,
  input  logic [1:0]         speed_i,
  input  logic [1:0]         ep_kind_i,
  output logic               space_ok_o,
  output logic [BURST_W-1:0] len_o
);
  logic               multi;
  logic               capped;
  logic [CNT_W-1:0]   need;
  logic [BURST_W-1:0] cap;

  always_comb begin
    multi  = cfg_i.thr_en & host_mode_i & (speed_i == SPEED_TOP);
    capped = multi & (ep_kind_e'(ep_kind_i) != EP_CTRL);
    need   = multi ? cfg_i.pkt_cnt : CNT_W'(1);
    cap    = capped ? cfg_i.burst : BURST_W'(MAX_BURST);
    space_ok_o = free_slots_i >= FREE_W'(need);
    len_o  = (free_slots_i >= FREE_W'(cap)) ? cap : BURST_W'(free_slots_i);
  end
endmodule

// File: rtl/rxadm_tracker.sv
module rxadm_tracker
  import rxadm_pkg::*;
#(
  parameter int MAX_BURST = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               space_ok_i,
  input  logic [BURST_W-1:0] len_i,
  input  logic               req_i,
  input  logic               pkt_rcvd_i,
  input  logic               burst_end_i,
  output logic               start_ok_o,
  output logic               active_o,
  output logic [BURST_W-1:0] grant_o,
  output logic [BURST_W-1:0] left_o
);
  logic start;

  assign start_ok_o = space_ok_i & ~active_o;
  assign start      = req_i & start_ok_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      grant_o  <= '0;
      left_o   <= '0;
    end else if (start) begin
      active_o <= 1'b1;
      grant_o  <= len_i;
      left_o   <= len_i;
    end else if (active_o) begin
      if (burst_end_i) begin
        active_o <= 1'b0;
        left_o   <= '0;
      end else if (pkt_rcvd_i) begin
        left_o <= left_o - BURST_W'(1);
        if (left_o == BURST_W'(1)) active_o <= 1'b0;
      end
    end
  end

  AST_NO_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> !start_ok_o); // R7
  AST_GRANT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && $past(active_o)) |-> $stable(grant_o)); // R6
  AST_GRANT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> (grant_o != '0) && (grant_o <= BURST_W'(MAX_BURST))); // R5
  AST_LEFT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> (left_o != '0) && (left_o <= grant_o)); // R7
  AST_END_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && burst_end_i && !req_i) |=> (!active_o && left_o == '0)); // R8
endmodule

// File: rtl/rx_burst_admit.sv
module rx_burst_admit
  import rxadm_pkg::*;
#(
  parameter int FREE_W    = 6,
  parameter int MAX_BURST = 16,
  parameter int RST_CNT   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_wr_i,
  input  logic               cfg_thr_en_i,
  input  logic [CNT_W-1:0]   cfg_pkt_cnt_i,
  input  logic [BURST_W-1:0] cfg_burst_i,
  input  logic [FREE_W-1:0]  free_slots_i,
  input  logic               host_mode_i,
  input  logic [1:0]         speed_i,
  input  logic [1:0]         ep_kind_i,
  input  logic               req_i,
  input  logic               pkt_rcvd_i,
  input  logic               burst_end_i,
  output logic               start_ok_o,
  output logic               burst_active_o,
  output logic [BURST_W-1:0] grant_len_o,
  output logic [BURST_W-1:0] pkts_left_o
);
  rxadm_cfg_t         cfg;
  logic               space_ok;
  logic [BURST_W-1:0] len;

  rxadm_cfg #(.MAX_BURST(MAX_BURST), .RST_CNT(RST_CNT)) u_cfg (
    .clk_i, .rst_ni,
    .wr_i      (cfg_wr_i),
    .thr_en_i  (cfg_thr_en_i),
    .pkt_cnt_i (cfg_pkt_cnt_i),
    .burst_i   (cfg_burst_i),
    .cfg_o     (cfg)
  );

  rxadm_policy #(.FREE_W(FREE_W), .MAX_BURST(MAX_BURST)) u_policy (
    .cfg_i        (cfg),
    .free_slots_i (free_slots_i),
    .host_mode_i  (host_mode_i),
    .speed_i      (speed_i),
    .ep_kind_i    (ep_kind_i),
    .space_ok_o   (space_ok),
    .len_o        (len)
  );

  rxadm_tracker #(.MAX_BURST(MAX_BURST)) u_trk (
    .clk_i, .rst_ni,
    .space_ok_i  (space_ok),
    .len_i       (len),
    .req_i       (req_i),
    .pkt_rcvd_i  (pkt_rcvd_i),
    .burst_end_i (burst_end_i),
    .start_ok_o  (start_ok_o),
    .active_o    (burst_active_o),
    .grant_o     (grant_len_o),
    .left_o      (pkts_left_o)
  );

  AST_PERMIT_SPACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_ok_o |-> (free_slots_i != '0)); // R1
endmodule

// File: tb/rx_burst_admit_test.sv
module rx_burst_admit_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0, cfg_en = 1'b0;
  logic [3:0] cfg_cnt = '0;
  logic [4:0] cfg_burst = '0;
  logic [5:0] free = '0;
  logic       host = 1'b1;
  logic [1:0] speed = 2'b11, kind = 2'd2;
  logic       req = 1'b0, pkt = 1'b0, bend = 1'b0;
  logic       ok, act;
  logic [4:0] grant, left;
  int         n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_burst_admit uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(cfg_wr), .cfg_thr_en_i(cfg_en),
    .cfg_pkt_cnt_i(cfg_cnt), .cfg_burst_i(cfg_burst), .free_slots_i(free),
    .host_mode_i(host), .speed_i(speed), .ep_kind_i(kind), .req_i(req),
    .pkt_rcvd_i(pkt), .burst_end_i(bend), .start_ok_o(ok),
    .burst_active_o(act), .grant_len_o(grant), .pkts_left_o(left)
  );

  task automatic check(string tag, int actual, int expected);
    n_run++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  task automatic write_cfg(logic en, logic [3:0] c, logic [4:0] b);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_en = en; cfg_cnt = c; cfg_burst = b;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic set_free(logic [5:0] f);
    @(negedge clk);
    free = f;
    #1;
  endtask

  task automatic start_burst(logic [5:0] f, logic [1:0] k);
    @(negedge clk);
    free = f; kind = k; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    #1;
  endtask

  task automatic pulse_pkt();
    @(negedge clk); pkt = 1'b1;
    @(negedge clk); pkt = 1'b0;
    #1;
  endtask

  task automatic pulse_end();
    @(negedge clk); bend = 1'b1;
    @(negedge clk); bend = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    check("R3 active", act, 0);
    check("R3 grant", grant, 0);
    check("R3 left", left, 0);
    host = 1'b1; speed = 2'b11; kind = 2'd2;
    set_free(6'd1);
    check("R3 cnt=2 free=1", ok, 0);
    set_free(6'd2);
    check("R3 cnt=2 free=2", ok, 1);
    start_burst(6'd40, 2'd2);
    check("R3 cap16", grant, 16);
    pulse_end();
  endtask

  task automatic t_one_pkt();
    write_cfg(1'b0, 4'd5, 5'd16);
    set_free(6'd1);
    check("R1 disabled free=1", ok, 1);
    set_free(6'd0);
    check("R1 free=0", ok, 0);
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0; #1;
    check("R1 req w/o permit", act, 0);
    write_cfg(1'b1, 4'd5, 5'd16);
    host = 1'b0;
    set_free(6'd1);
    check("R1 device mode", ok, 1);
    host = 1'b1; speed = 2'b10;
    set_free(6'd1);
    check("R1 lower speed", ok, 1);
    speed = 2'b11;
  endtask

  task automatic t_thresh();
    write_cfg(1'b1, 4'd5, 5'd16);
    set_free(6'd4);
    check("R2 free=4 cnt=5", ok, 0);
    set_free(6'd5);
    check("R2 free=5 cnt=5", ok, 1);
    write_cfg(1'b1, 4'd15, 5'd16);
    set_free(6'd14);
    check("R2 free=14 cnt=15", ok, 0);
  endtask

  task automatic t_clamp();
    write_cfg(1'b1, 4'd0, 5'd0);
    set_free(6'd1);
    check("R4 cnt0 acts as 1", ok, 1);
    start_burst(6'd10, 2'd2);
    check("R4 burst0 acts as 1", grant, 1);
    pulse_end();
    write_cfg(1'b1, 4'd1, 5'd31);
    start_burst(6'd40, 2'd2);
    check("R4 burst31 acts as 16", grant, 16);
    pulse_end();
  endtask

  task automatic t_grant();
    write_cfg(1'b1, 4'd1, 5'd4);
    start_burst(6'd10, 2'd2);
    check("R5 bulk capped", grant, 4);
    pulse_end();
    start_burst(6'd10, 2'd0);
    check("R5 control uncapped", grant, 10);
    pulse_end();
    start_burst(6'd9, 2'd1);
    check("R5 isoc capped", grant, 4);
    pulse_end();
    write_cfg(1'b1, 4'd1, 5'd8);
    start_burst(6'd3, 2'd3);
    check("R5 free below cap", grant, 3);
    pulse_end();
    write_cfg(1'b0, 4'd1, 5'd4);
    start_burst(6'd10, 2'd2);
    check("R5 disabled uncapped", grant, 10);
    pulse_end();
  endtask

  task automatic t_count();
    write_cfg(1'b1, 4'd1, 5'd3);
    start_burst(6'd20, 2'd2);
    check("R7 active", act, 1);
    check("R7 left=3", left, 3);
    check("R7 no permit busy", ok, 0);
    pulse_pkt();
    check("R7 left=2", left, 2);
    write_cfg(1'b1, 4'd1, 5'd1);
    check("R6 grant held", grant, 3);
    pulse_pkt();
    check("R7 left=1", left, 1);
    pulse_pkt();
    check("R7 done", act, 0);
    check("R7 left=0", left, 0);
    start_burst(6'd20, 2'd2);
    check("R9 new cap used", grant, 1);
    pulse_pkt();
    check("R7 single done", act, 0);
  endtask

  task automatic t_abort();
    write_cfg(1'b1, 4'd1, 5'd6);
    start_burst(6'd20, 2'd2);
    pulse_pkt();
    check("R8 pre-abort left", left, 5);
    pulse_end();
    check("R8 ended", act, 0);
    check("R8 left cleared", left, 0);
    check("R8 permit back", ok, 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_one_pkt();
        t_thresh();
        t_clamp();
        t_grant();
        t_count();
        t_abort();
      end
      begin
        repeat (5000) @(posedge clk);
        check("watchdog", 1, 0);
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule